// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block commits a processor trap in the single clock cycle in which a trap request is raised. From the trap cause, the exception PC, an optional faulting address, the current privilege level and the current status bits, it decides where the trap is handled. The trap can go to the supervisor handler, to the machine handler, or to debug mode. If debug mode is already active, the trap is instead redirected inside it. The block then loads the new PC and privilege, the per-mode cause, return-address and bad-address registers, and the status word.

A trap is handled in supervisor mode only when three conditions hold: the core runs below machine level, the cause index fits within the register width, and the matching bit in the interrupt or exception delegation mask is set. Machine-mode interrupts may be vectored off the trap base. A breakpoint can instead capture the core into debug mode, as chosen by a per-privilege enable. After a handled trap the block gives a one-cycle pulse, which the memory side uses to drop any outstanding load reservation.

Top module: `trap_entry_unit`

## Requirements
- R1: Reset state. After reset, `pc_o` equals the RESET_PC parameter and `priv_o` is machine (3). The status word, all cause, return-address and bad-address registers, the debug registers and `clr_resv_o` are zero. Privilege codes are user 0, supervisor 1, reserved 2 and machine 3.
- R2: Traps while in debug mode. Debug mode is active while `dbg_cause_o` is non-zero. A requested trap in this state loads `pc_o` with DBG_ENTRY_PC if it is a breakpoint, and with DBG_EXC_PC otherwise. Privilege, status, all trap registers, the debug registers and `clr_resv_o` stay unchanged.
- R3: Debug capture. A breakpoint is cause value 3 with bit XLEN-1 clear. Outside debug mode, a breakpoint whose privilege has its bit set in `ebreak_en_i` enters debug mode. That bit is bit 0 for user, bit 1 for supervisor and bit 2 for machine. On entry, `dbg_cause_o` becomes 1, `dbg_prv_o` takes the old privilege, `dpc_o` takes `epc_i`, `pc_o` becomes DBG_ENTRY_PC and `priv_o` becomes machine. Status, the trap registers and `clr_resv_o` are not touched.
- R4: Routing. Cause bit XLEN-1 marks an interrupt, and the remaining bits form the index. Interrupts look up `ideleg_i` and exceptions look up `edeleg_i`. The trap goes to supervisor only if the privilege is user or supervisor, the index is below XLEN, and the mask bit at that index is set. Every other trap goes to machine, and so does a trap raised at reserved privilege 2. An index of XLEN or more never wraps onto a lower mask bit.
- R5: Supervisor entry. `pc_o` becomes `stvec_i` and `priv_o` becomes 1. `scause_o` takes `cause_i` and `sepc_o` takes `epc_i`. The status word uses bit 0 for SIE, bit 1 for MIE, bit 2 for SPIE, bit 3 for MPIE, bit 4 for SPP and bits 6:5 for MPP. In the status word, SPIE takes the old SIE, SPP takes bit 0 of the old privilege and SIE clears. The other fields are copied from `status_i`.
- R6: Machine target PC. `pc_o` becomes `mtvec_i` with bit 0 forced to 0. When `mtvec_i` bit 0 is set and the trap is an interrupt, four times the cause index is added.
- R7: Machine entry. `priv_o` becomes 3, `mcause_o` takes `cause_i` and `mepc_o` takes `epc_i`. MPIE takes the old MIE, MPP takes the old privilege and MIE clears. The other status fields are copied from `status_i`.
- R8: Bad address. The bad-address register of the target mode loads `bad_i` only when `has_bad_i` is set; otherwise it holds its value. The other mode's registers never change.
- R9: Reservation clear. `clr_resv_o` is high for exactly the cycle that follows a supervisor or machine entry, and is low after debug capture, after debug redirection and after idle cycles.
- R10: Idle. While `trap_req_i` is low, no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req_i | input | 1 | Commit a trap this cycle |
| cause_i | input | XLEN | Trap cause, MSB set for interrupts |
| epc_i | input | XLEN | PC of the trapping instruction |
| bad_i | input | XLEN | Faulting address |
| has_bad_i | input | 1 | `bad_i` is valid for this trap |
| cur_priv_i | input | 2 | Current privilege |
| status_i | input | 7 | Current status word |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| edeleg_i | input | XLEN | Exception delegation mask |
| stvec_i | input | XLEN | Supervisor trap base |
| mtvec_i | input | XLEN | Machine trap base, bit 0 selects vectoring |
| ebreak_en_i | input | 3 | Breakpoint-to-debug enable per privilege |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | Next privilege |
| status_o | output | 7 | Status word written by the last entry |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor return address |
| sbad_o | output | XLEN | Supervisor bad address |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine return address |
| mbad_o | output | XLEN | Machine bad address |
| dbg_cause_o | output | 3 | Debug cause, non-zero while in debug mode |
| dbg_prv_o | output | 2 | Privilege at debug entry |
| dpc_o | output | XLEN | PC saved at debug entry |
| clr_resv_o | output | 1 | One-cycle load-reservation clear |

## Verification
The assertions check, on every cycle, the rules that can be seen from one request edge to the next. They cover the freeze of privilege, status and trap registers while in debug mode, the split between the debug entry PC and the debug exception PC, and the privilege and enable-bit changes on supervisor and machine entry. They also cover holding the bad address when none is supplied, the origin of every reservation-clear pulse, and the idle hold. Some behaviour can only be shown by the bench's scenarios. These are the routing decision, checked across privileges, delegation masks and an out-of-range cause index, and the exact vectored machine PC. The bench also shows that an interrupt with code 3 is not taken for a breakpoint, that breakpoint capture depends on the enable bit of the current privilege, and that the cause, return address and bad address land in the correct mode's registers.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  localparam logic [1:0] PRIV_U   = 2'd0;
  localparam logic [1:0] PRIV_S   = 2'd1;
  localparam logic [1:0] PRIV_M   = 2'd3;

  localparam int ST_W    = 7;
  localparam int ST_SIE  = 0;
  localparam int ST_MIE  = 1;
  localparam int ST_SPIE = 2;
  localparam int ST_MPIE = 3;
  localparam int ST_SPP  = 4;
  localparam int ST_MPP  = 5;

  localparam int          BKPT_CODE      = 3;
  localparam logic [2:0]  DBG_CAUSE_SWBP = 3'd1;

  typedef enum logic [1:0] {
    ROUTE_DBG_REDIR,
    ROUTE_DBG_ENTER,
    ROUTE_SUP,
    ROUTE_MACH
  } route_e;
endpackage

// File: rtl/trap_router.sv
`timescale 1ns/1ps
module trap_router
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              in_debug_i,
  input  logic [XLEN-1:0]   cause_i,
  input  logic [1:0]        cur_priv_i,
  input  logic [XLEN-1:0]   ideleg_i,
  input  logic [XLEN-1:0]   edeleg_i,
  input  logic [2:0]        ebreak_en_i,
  output route_e            route_o,
  output logic              is_irq_o,
  output logic              is_bkpt_o,
  output logic [XLEN-2:0]   index_o
);
  localparam int IDXW = XLEN - 1;
  localparam int SELW = $clog2(XLEN);

  logic [XLEN-1:0] mask;
  logic            in_range;
  logic            deleg_bit;
  logic            low_priv;
  logic            bk_enabled;

  always_comb begin
    is_irq_o   = cause_i[XLEN-1];
    index_o    = cause_i[XLEN-2:0];
    is_bkpt_o  = (cause_i == XLEN'(BKPT_CODE));
    mask       = is_irq_o ? ideleg_i : edeleg_i;
    in_range   = (index_o < IDXW'(XLEN));
    deleg_bit  = in_range ? mask[index_o[SELW-1:0]] : 1'b0;
    low_priv   = (cur_priv_i == PRIV_U) || (cur_priv_i == PRIV_S);
    case (cur_priv_i)
      PRIV_U:  bk_enabled = ebreak_en_i[0];
      PRIV_S:  bk_enabled = ebreak_en_i[1];
      PRIV_M:  bk_enabled = ebreak_en_i[2];
      default: bk_enabled = 1'b0;
    endcase
    if (in_debug_i)                     route_o = ROUTE_DBG_REDIR;
    else if (is_bkpt_o && bk_enabled)   route_o = ROUTE_DBG_ENTER;
    else if (low_priv && deleg_bit)     route_o = ROUTE_SUP;
    else                                route_o = ROUTE_MACH;
  end
endmodule

// File: rtl/trap_mode_bank.sv
`timescale 1ns/1ps
module trap_mode_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            wr_bad_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] bad_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] bad_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_o <= '0;
      epc_o   <= '0;
      bad_o   <= '0;
    end else if (wr_i) begin
      cause_o <= cause_i;
      epc_o   <= epc_i;
      if (wr_bad_i) bad_o <= bad_i;
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
`timescale 1ns/1ps
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int               XLEN         = 32,
  parameter logic [XLEN-1:0]  RESET_PC     = 32'h8000_0000,
  parameter logic [XLEN-1:0]  DBG_ENTRY_PC = 32'h0000_0800,
  parameter logic [XLEN-1:0]  DBG_EXC_PC   = 32'h0000_0808
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req_i,
  input  logic [XLEN-1:0]   cause_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [XLEN-1:0]   bad_i,
  input  logic              has_bad_i,
  input  logic [1:0]        cur_priv_i,
  input  logic [6:0]        status_i,
  input  logic [XLEN-1:0]   ideleg_i,
  input  logic [XLEN-1:0]   edeleg_i,
  input  logic [XLEN-1:0]   stvec_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [2:0]        ebreak_en_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [1:0]        priv_o,
  output logic [6:0]        status_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   sbad_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mbad_o,
  output logic [2:0]        dbg_cause_o,
  output logic [1:0]        dbg_prv_o,
  output logic [XLEN-1:0]   dpc_o,
  output logic              clr_resv_o
);
  localparam int NBANK = 2;  // 0: supervisor, 1: machine

  // Arithmetic kept in functions so the rules read in one place.
  function automatic logic [XLEN-1:0] mach_pc(input logic [XLEN-1:0] base,
                                               input logic irq,
                                               input logic [XLEN-2:0] idx);
    logic [XLEN-1:0] aligned;
    logic [XLEN-1:0] offs;
    aligned = {base[XLEN-1:1], 1'b0};
    offs    = (base[0] && irq) ? ({1'b0, idx} << 2) : '0;
    return aligned + offs;
  endfunction

  function automatic logic [ST_W-1:0] sup_status(input logic [ST_W-1:0] old,
                                                 input logic [1:0] prv);
    logic [ST_W-1:0] s;
    s          = old;
    s[ST_SPIE] = old[ST_SIE];
    s[ST_SPP]  = prv[0];
    s[ST_SIE]  = 1'b0;
    return s;
  endfunction

  function automatic logic [ST_W-1:0] mach_status(input logic [ST_W-1:0] old,
                                                  input logic [1:0] prv);
    logic [ST_W-1:0] s;
    s            = old;
    s[ST_MPIE]   = old[ST_MIE];
    s[ST_MPP+:2] = prv;
    s[ST_MIE]    = 1'b0;
    return s;
  endfunction

  // Named internal events
  route_e          route;
  logic            is_irq, is_bkpt;
  logic [XLEN-2:0] cause_idx;
  logic            in_debug;
  logic            sup_take, mach_take, dbg_enter, dbg_redir;

  assign in_debug  = |dbg_cause_o;
  assign sup_take  = trap_req_i && (route == ROUTE_SUP);
  assign mach_take = trap_req_i && (route == ROUTE_MACH);
  assign dbg_enter = trap_req_i && (route == ROUTE_DBG_ENTER);
  assign dbg_redir = trap_req_i && (route == ROUTE_DBG_REDIR);

  trap_router #(.XLEN(XLEN)) u_router (
    .in_debug_i  (in_debug),
    .cause_i     (cause_i),
    .cur_priv_i  (cur_priv_i),
    .ideleg_i    (ideleg_i),
    .edeleg_i    (edeleg_i),
    .ebreak_en_i (ebreak_en_i),
    .route_o     (route),
    .is_irq_o    (is_irq),
    .is_bkpt_o   (is_bkpt),
    .index_o     (cause_idx)
  );

  logic [XLEN-1:0] bank_cause [NBANK];
  logic [XLEN-1:0] bank_epc   [NBANK];
  logic [XLEN-1:0] bank_bad   [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wr;
    assign wr = (b == 0) ? sup_take : mach_take;
    trap_mode_bank #(.XLEN(XLEN)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr),
      .wr_bad_i (has_bad_i),
      .cause_i  (cause_i),
      .epc_i    (epc_i),
      .bad_i    (bad_i),
      .cause_o  (bank_cause[b]),
      .epc_o    (bank_epc[b]),
      .bad_o    (bank_bad[b])
    );
  end

  assign scause_o = bank_cause[0];
  assign sepc_o   = bank_epc[0];
  assign sbad_o   = bank_bad[0];
  assign mcause_o = bank_cause[1];
  assign mepc_o   = bank_epc[1];
  assign mbad_o   = bank_bad[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o        <= RESET_PC;
      priv_o      <= PRIV_M;
      status_o    <= '0;
      dbg_cause_o <= '0;
      dbg_prv_o   <= '0;
      dpc_o       <= '0;
      clr_resv_o  <= 1'b0;
    end else begin
      clr_resv_o <= sup_take || mach_take;
      if (dbg_redir) begin
        pc_o <= is_bkpt ? DBG_ENTRY_PC : DBG_EXC_PC;
      end else if (dbg_enter) begin
        pc_o        <= DBG_ENTRY_PC;
        priv_o      <= PRIV_M;
        dbg_cause_o <= DBG_CAUSE_SWBP;
        dbg_prv_o   <= cur_priv_i;
        dpc_o       <= epc_i;
      end else if (sup_take) begin
        pc_o     <= stvec_i;
        priv_o   <= PRIV_S;
        status_o <= sup_status(status_i, cur_priv_i);
      end else if (mach_take) begin
        pc_o     <= mach_pc(mtvec_i, is_irq, cause_idx);
        priv_o   <= PRIV_M;
        status_o <= mach_status(status_i, cur_priv_i);
      end
    end
  end

  // Assertions next to the logic they guard
  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_redir |=> $stable(priv_o) && $stable(status_o) && $stable(mcause_o)
                  && $stable(scause_o) && $stable(dpc_o) && !clr_resv_o); // R2
  AST_DBG_BKPT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug && trap_req_i && is_bkpt |=> pc_o == DBG_ENTRY_PC); // R2
  AST_DBG_EXC_PC: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug && trap_req_i && !is_bkpt |=> pc_o == DBG_EXC_PC); // R2
  AST_DBG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |=> priv_o == PRIV_M && dbg_cause_o != 3'd0
                  && dpc_o == $past(epc_i) && $stable(status_o)); // R3
  AST_SUP_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sup_take |-> (cur_priv_i == PRIV_U || cur_priv_i == PRIV_S)); // R4
  AST_SUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    sup_take |=> priv_o == PRIV_S && !status_o[ST_SIE]
                 && status_o[ST_SPIE] == $past(status_i[ST_SIE])); // R5
  AST_MACH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    mach_take |=> priv_o == PRIV_M && !status_o[ST_MIE]
                  && status_o[ST_MPIE] == $past(status_i[ST_MIE])
                  && mcause_o == $past(cause_i)); // R7
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_i && !has_bad_i |=> $stable(sbad_o) && $stable(mbad_o)); // R8
  AST_CLR_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_resv_o |-> $past(sup_take || mach_take)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req_i |=> $stable(pc_o) && $stable(priv_o) && $stable(status_o)
                    && $stable(dbg_cause_o) && !clr_resv_o); // R10
endmodule

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;
  localparam logic [31:0] RST_PC  = 32'h8000_0000;
  localparam logic [31:0] D_ENTRY = 32'h0000_0800;
  localparam logic [31:0] D_EXC   = 32'h0000_0808;
  localparam logic [31:0] STVEC   = 32'h0000_4000;
  localparam logic [31:0] IDELEG  = 32'h0000_0222;
  localparam logic [31:0] EDELEG  = 32'h0000_0108;

  typedef struct packed {
    logic [1:0]  prv;
    logic [6:0]  st;
    logic [31:0] cause;
    logic [31:0] mtvec;
    logic [31:0] e_pc;
    logic [1:0]  e_prv;
    logic [6:0]  e_st;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TABLE [NV] = '{
    '{2'd0, 7'b0000001, 32'h0000_0008, 32'h0000_0100, STVEC,         2'd1, 7'b0000100},
    '{2'd1, 7'b0000011, 32'h8000_0005, 32'h0000_0100, STVEC,         2'd1, 7'b0010110},
    '{2'd3, 7'b0000010, 32'h0000_0008, 32'h0000_0201, 32'h0000_0200, 2'd3, 7'b1101000},
    '{2'd0, 7'b0000000, 32'h8000_0007, 32'h0000_0301, 32'h0000_031C, 2'd3, 7'b0000000},
    '{2'd1, 7'b0000011, 32'h0000_0002, 32'h0000_0400, 32'h0000_0400, 2'd3, 7'b0101001},
    '{2'd0, 7'b0000000, 32'h8000_0009, 32'h0000_0501, STVEC,         2'd1, 7'b0000000},
    '{2'd1, 7'b0000000, 32'h0000_0028, 32'h0000_0600, 32'h0000_0600, 2'd3, 7'b0100000},
    '{2'd2, 7'b0000000, 32'h0000_0008, 32'h0000_0700, 32'h0000_0700, 2'd3, 7'b1000000},
    '{2'd3, 7'b0000010, 32'h8000_0003, 32'h0000_0801, 32'h0000_080C, 2'd3, 7'b1101000},
    '{2'd0, 7'b0000001, 32'h0000_0003, 32'h0000_0900, STVEC,         2'd1, 7'b0000100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0;
  logic [31:0] cause = '0, epc = '0, bad = '0;
  logic        has_bad = 1'b0;
  logic [1:0]  cur_priv = 2'd3;
  logic [6:0]  status_in = '0;
  logic [31:0] mtvec = '0;
  logic [2:0]  ebreak_en = 3'b000;
  logic [31:0] pc, scause, sepc, sbad, mcause, mepc, mbad, dpc;
  logic [1:0]  priv, dbg_prv;
  logic [6:0]  status;
  logic [2:0]  dbg_cause;
  logic        clr_resv;

  int n_chk = 0;
  int n_fail = 0;

  // model of the trap registers
  logic [31:0] m_sc = '0, m_se = '0, m_sb = '0, m_mc = '0, m_me = '0, m_mb = '0;
  logic [6:0]  m_st = '0;

  always #10 clk = ~clk;

  trap_entry_unit uut (
    .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .cause_i(cause),
    .epc_i(epc), .bad_i(bad), .has_bad_i(has_bad), .cur_priv_i(cur_priv),
    .status_i(status_in), .ideleg_i(IDELEG), .edeleg_i(EDELEG),
    .stvec_i(STVEC), .mtvec_i(mtvec), .ebreak_en_i(ebreak_en),
    .pc_o(pc), .priv_o(priv), .status_o(status), .scause_o(scause),
    .sepc_o(sepc), .sbad_o(sbad), .mcause_o(mcause), .mepc_o(mepc),
    .mbad_o(mbad), .dbg_cause_o(dbg_cause), .dbg_prv_o(dbg_prv),
    .dpc_o(dpc), .clr_resv_o(clr_resv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] p, input logic [6:0] s, input logic [31:0] c,
                      input logic [31:0] e, input logic hb, input logic [31:0] b);
    cur_priv = p; status_in = s; cause = c; epc = e; has_bad = hb; bad = b;
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
  endtask

  task automatic chk_banks(input string tag);
    chk({tag, " scause"}, scause, m_sc);
    chk({tag, " sepc"},   sepc,   m_se);
    chk({tag, " sbad"},   sbad,   m_sb);
    chk({tag, " mcause"}, mcause, m_mc);
    chk({tag, " mepc"},   mepc,   m_me);
    chk({tag, " mbad"},   mbad,   m_mb);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL R10 watchdog expired act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc, RST_PC);
    chk("R1 priv", 32'(priv), 32'd3);
    chk("R1 status", 32'(status), 32'd0);
    chk("R1 dbg_cause", 32'(dbg_cause), 32'd0);
    chk("R1 clr", 32'(clr_resv), 32'd0);
    chk_banks("R1");

    // Table of routed traps: R4 R5 R6 R7 R8 R9
    ebreak_en = 3'b100;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] e, b;
      logic        hb;
      e  = 32'h1000 + 32'(i * 4);
      b  = 32'hBAD0_0000 + 32'(i);
      hb = (i % 2) == 1;
      mtvec = TABLE[i].mtvec;
      fire(TABLE[i].prv, TABLE[i].st, TABLE[i].cause, e, hb, b);
      if (TABLE[i].e_prv == 2'd1) begin
        m_sc = TABLE[i].cause; m_se = e; if (hb) m_sb = b;
      end else begin
        m_mc = TABLE[i].cause; m_me = e; if (hb) m_mb = b;
      end
      m_st = TABLE[i].e_st;
      chk($sformatf("R4/R6 vec%0d pc", i), pc, TABLE[i].e_pc);
      chk($sformatf("R4 vec%0d priv", i), 32'(priv), 32'(TABLE[i].e_prv));
      chk($sformatf("R5/R7 vec%0d status", i), 32'(status), 32'(m_st));
      chk($sformatf("R9 vec%0d clr high", i), 32'(clr_resv), 32'd1);
      chk_banks($sformatf("R5/R7/R8 vec%0d", i));
      @(negedge clk);
      chk($sformatf("R9 vec%0d clr low", i), 32'(clr_resv), 32'd0);
      chk($sformatf("R10 vec%0d pc hold", i), pc, TABLE[i].e_pc);
    end

    // R10: idle with changing inputs
    cause = 32'h8000_0001; status_in = 7'h7F; cur_priv = 2'd0; epc = 32'hFFFF; has_bad = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle pc", pc, STVEC);
    chk("R10 idle status", 32'(status), 32'(m_st));
    chk_banks("R10 idle");

    // R3: breakpoint capture at supervisor with supervisor enable
    ebreak_en = 3'b010;
    fire(2'd1, 7'b0000011, 32'h0000_0003, 32'h0000_2222, 1'b1, 32'h5555);
    chk("R3 pc", pc, D_ENTRY);
    chk("R3 priv", 32'(priv), 32'd3);
    chk("R3 dbg_cause", 32'(dbg_cause), 32'd1);
    chk("R3 dbg_prv", 32'(dbg_prv), 32'd1);
    chk("R3 dpc", dpc, 32'h0000_2222);
    chk("R3 status", 32'(status), 32'(m_st));
    chk("R3 clr", 32'(clr_resv), 32'd0);
    chk_banks("R3");

    // R2: traps while in debug mode
    fire(2'd0, 7'b0000001, 32'h0000_0005, 32'h0000_3333, 1'b1, 32'h6666);
    chk("R2 exc pc", pc, D_EXC);
    chk("R2 priv", 32'(priv), 32'd3);
    chk("R2 dpc", dpc, 32'h0000_2222);
    chk("R2 status", 32'(status), 32'(m_st));
    chk("R2 clr", 32'(clr_resv), 32'd0);
    chk_banks("R2");
    fire(2'd0, 7'b0000001, 32'h0000_0003, 32'h0000_4444, 1'b0, 32'h0);
    chk("R2 bkpt pc", pc, D_ENTRY);
    chk("R2 dbg_prv", 32'(dbg_prv), 32'd1);

    // R1 again after reset exits debug mode
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_sc = '0; m_se = '0; m_sb = '0; m_mc = '0; m_me = '0; m_mb = '0;
    chk("R1 re-reset pc", pc, RST_PC);
    chk("R1 re-reset dbg_cause", 32'(dbg_cause), 32'd0);
    chk("R1 re-reset dpc", dpc, 32'd0);
    chk_banks("R1 re-reset");

    // R7 after reset: machine-level trap, vectored interrupt at index 11
    mtvec = 32'h0000_1001;
    fire(2'd3, 7'b0000010, 32'h8000_000B, 32'h0000_7000, 1'b0, 32'h0);
    chk("R6 idx11 pc", pc, 32'h0000_102C);
    chk("R7 idx11 mcause", mcause, 32'h8000_000B);
    chk("R7 idx11 status", 32'(status), 32'h68);
    chk("R8 idx11 mbad hold", mbad, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule